// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block decides which interrupt source the CPU services next. It watches one reset request, one non-maskable interrupt pin and a bus of maskable request lines. It ranks them by a fixed hardware order and presents three outputs: a pending flag, the 16-bit vector address of the winning source and a one-hot acknowledge. The acknowledge lets the peripheral that owns the serviced line clear its own flag in hardware.

The non-maskable pin may change at any time relative to the clock. It passes through a two-flop synchronizer and an edge detector, and a rising edge sets a pending latch. The latch is gated by its own enable rather than the global interrupt enable. It clears only when the CPU accepts that interrupt. The maskable lines are expected to be synchronous already, and the global enable gates them. The CPU sequencer raises `take` for one cycle when it starts servicing the pending source. In that same cycle the acknowledge fires for the line being serviced.

Top module: `irq_vector_arb`

## Requirements
- R1: After `rst_n` is released with all requests low, `pend` is 0, `irq_ack` is all zero and no non-maskable interrupt is pending.
- R2: While `boot_req` is high, `pend` is 1 and `vec_addr` is 16'hFFFE whatever else is requested, and `irq_ack` stays zero even when `take` is high.
- R3: A pending non-maskable interrupt outranks every maskable line and gives `vec_addr` 16'hFFFC. It is presented only while `nmi_en` is 1, and `gie` has no effect on it.
- R4: Maskable line n is bit n of `irq_req` and has vector 16'hFFE0 + 2*n. When several lines are high, the highest index wins.
- R5: While `gie` is 0, the maskable lines are ignored: they raise no `pend` and no `irq_ack`.
- R6: `irq_ack` is zero except in a cycle where `take` is 1 and maskable line n is the winner. In that cycle it equals the one-hot value with only bit n set.
- R7: A rising edge on `nmi_pin` sets the pending latch, which becomes visible at `pend` on the third rising clock edge after the pin rises. A pin held high does not set the latch again.
- R8: The pending latch clears at the clock edge that ends a cycle in which `take` is 1 and the non-maskable interrupt is the winner. Otherwise it holds, including while `nmi_en` is 0.
- R9: While `pend` is 0, `vec_addr` is 16'h0000.
- R10: `take` while nothing is pending has no effect: `irq_ack` stays zero and a later enable still finds the earlier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_req | input | 1 | Reset-vector request, highest priority |
| irq_req | input | 14 | Maskable request lines, bit n is line n |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt input |
| gie | input | 1 | Global enable for maskable lines |
| nmi_en | input | 1 | Enable for the non-maskable interrupt |
| take | input | 1 | CPU accepts the pending source this cycle |
| pend | output | 1 | Some enabled source is pending |
| vec_addr | output | 16 | Vector address of the winning source |
| irq_ack | output | 14 | One-hot acknowledge of the serviced line |

## Verification
The bench targets the priority edges: line 13 against line 0, every single line alone, and the non-maskable interrupt and reset request against a full bus of lines. A design with an inverted or off-by-one encoder would give the wrong vector in these cases. It also measures when the pin edge first shows at `pend`, and checks that a pin held high does not set the latch a second time. A synchronizer of the wrong depth, or a level-sensitive latch, would fail these checks. Masking is checked in both directions. The latch must survive a disabled period and `take` while idle, and it must clear only on its own accept. A design that gated it with `gie` or cleared it on any `take` would lose or repeat the interrupt.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int VEC_W        = 16;
  localparam logic [VEC_W-1:0] BOOT_VEC = 16'hFFFE;
  localparam logic [VEC_W-1:0] NMI_VEC  = 16'hFFFC;
  localparam logic [VEC_W-1:0] IDLE_VEC = 16'h0000;

  // Maskable vectors sit just below the non-maskable one, two bytes apart.
  function automatic logic [VEC_W-1:0] line_vec(input int unsigned n, input int unsigned lines);
    logic [VEC_W-1:0] base;
    base = NMI_VEC - VEC_W'(2 * lines);
    return base + VEC_W'(2 * n);
  endfunction

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_LINE = 2'd1,
    WIN_NMI  = 2'd2,
    WIN_BOOT = 2'd3
  } win_e;

endpackage

// File: rtl/nmi_capture.sv
module nmi_capture #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clr,
  output logic rise,
  output logic pending
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // A fresh edge wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pending <= 1'b0;
    else if (rise) pending <= 1'b1;
    else if (clr)  pending <= 1'b0;
  end

endmodule

// File: rtl/line_prio.sv
module line_prio #(
  parameter int NUM_IRQ = 14,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] lines,
  output logic               found,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_IRQ-1:0] grant
);

  logic [NUM_IRQ:0] above;

  assign above[NUM_IRQ] = 1'b0;

  generate
    for (genvar i = NUM_IRQ - 1; i >= 0; i--) begin : g_chain
      assign grant[i] = lines[i] & ~above[i+1];
      assign above[i] = lines[i] | above[i+1];
    end
  endgenerate

  assign found = above[0];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb
  import irq_vec_pkg::*;
#(
  parameter int NUM_IRQ     = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               nmi_pin,
  input  logic               gie,
  input  logic               nmi_en,
  input  logic               take,
  output logic               pend,
  output logic [VEC_W-1:0]   vec_addr,
  output logic [NUM_IRQ-1:0] irq_ack
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic               nmi_rise;
  logic               nmi_pend;
  logic               nmi_live;
  logic               nmi_clr;
  logic [NUM_IRQ-1:0] masked;
  logic               line_found;
  logic [IDX_W-1:0]   line_idx;
  logic [NUM_IRQ-1:0] line_grant;
  win_e               winner;
  logic               win_nmi;

  nmi_capture #(.STAGES(SYNC_STAGES)) u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (nmi_pin),
    .clr     (nmi_clr),
    .rise    (nmi_rise),
    .pending (nmi_pend)
  );

  assign masked   = gie ? irq_req : '0;
  assign nmi_live = nmi_pend & nmi_en;

  line_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .lines (masked),
    .found (line_found),
    .idx   (line_idx),
    .grant (line_grant)
  );

  always_comb begin
    if (boot_req)        winner = WIN_BOOT;
    else if (nmi_live)   winner = WIN_NMI;
    else if (line_found) winner = WIN_LINE;
    else                 winner = WIN_NONE;
  end

  assign win_nmi = (winner == WIN_NMI);
  assign nmi_clr = take & win_nmi;
  assign pend    = (winner != WIN_NONE);

  always_comb begin
    unique case (winner)
      WIN_BOOT: vec_addr = BOOT_VEC;
      WIN_NMI:  vec_addr = NMI_VEC;
      WIN_LINE: vec_addr = line_vec(int'(line_idx), NUM_IRQ);
      default:  vec_addr = IDLE_VEC;
    endcase
  end

  assign irq_ack = (take && winner == WIN_LINE) ? line_grant : '0;

endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
  parameter int NUM_IRQ = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               boot_req,
  input logic [NUM_IRQ-1:0] irq_req,
  input logic               gie,
  input logic               nmi_en,
  input logic               take,
  input logic               pend,
  input logic [15:0]        vec_addr,
  input logic [NUM_IRQ-1:0] irq_ack,
  input logic               nmi_pend,
  input logic               nmi_rise,
  input logic               win_nmi
);

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack)); // R6
  AST_ACK_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> (take && gie && !boot_req)); // R6
  AST_ACK_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> ((irq_ack & irq_req) == irq_ack)); // R4
  AST_BOOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    boot_req |-> (pend && vec_addr == 16'hFFFE && irq_ack == '0)); // R2
  AST_NMI_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    win_nmi |-> (vec_addr == 16'hFFFC && irq_ack == '0)); // R3
  AST_GIE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie && !boot_req && !(nmi_pend && nmi_en)) |-> !pend); // R5
  AST_NMI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rise |=> nmi_pend); // R7
  AST_NMI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && win_nmi && !nmi_rise) |=> !nmi_pend); // R8
  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !(take && win_nmi)) |=> nmi_pend); // R8
  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> (vec_addr == 16'h0000 && irq_ack == '0)); // R9

endmodule

bind irq_vector_arb irq_vector_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .boot_req (boot_req),
  .irq_req  (irq_req),
  .gie      (gie),
  .nmi_en   (nmi_en),
  .take     (take),
  .pend     (pend),
  .vec_addr (vec_addr),
  .irq_ack  (irq_ack),
  .nmi_pend (nmi_pend),
  .nmi_rise (nmi_rise),
  .win_nmi  (win_nmi)
);

// File: tb/test_irq_vector_arb.sv
module test_irq_vector_arb;

  localparam int N = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          boot_req = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic          nmi_pin = 1'b0;
  logic          gie = 1'b0;
  logic          nmi_en = 1'b0;
  logic          take = 1'b0;
  logic          pend;
  logic [15:0]   vec_addr;
  logic [N-1:0]  irq_ack;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_vector_arb i_irq_vector_arb (
    .clk(clk), .rst_n(rst_n), .boot_req(boot_req), .irq_req(irq_req),
    .nmi_pin(nmi_pin), .gie(gie), .nmi_en(nmi_en), .take(take),
    .pend(pend), .vec_addr(vec_addr), .irq_ack(irq_ack)
  );

  function automatic logic [15:0] exp_vec(input int n);
    return 16'hFFE0 + 16'(n << 1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Inputs change on the falling edge; outputs are sampled 2 ns later.
  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic t_reset();
    settle();
    check("R1 pend", 32'(pend), 32'd0);
    check("R1 ack", 32'(irq_ack), 32'd0);
    check("R9 idle vec", 32'(vec_addr), 32'h0);
    gie = 1'b1; nmi_en = 1'b1; #2;
    check("R1 no nmi after reset", 32'(pend), 32'd0);
    gie = 1'b0; nmi_en = 1'b0;
  endtask

  task automatic t_single_lines();
    gie = 1'b1;
    for (int n = 0; n < N; n++) begin
      settle();
      irq_req = N'(1) << n; #2;
      check("R4 single line vec", 32'(vec_addr), 32'(exp_vec(n)));
      check("R6 no ack without take", 32'(irq_ack), 32'd0);
      take = 1'b1; #2;
      check("R6 ack onehot", 32'(irq_ack), 32'(N'(1) << n));
      take = 1'b0;
    end
    settle();
    irq_req = '0; gie = 1'b0; #2;
  endtask

  task automatic t_priority();
    gie = 1'b1;
    settle();
    irq_req = '1; #2;
    check("R4 all lines -> 13", 32'(vec_addr), 32'hFFFA);
    irq_req = 14'b00_0000_0010_0001; #2;
    check("R4 5 over 0", 32'(vec_addr), 32'hFFEA);
    take = 1'b1; #2;
    check("R6 ack only winner", 32'(irq_ack), 32'h20);
    take = 1'b0;
    settle();
    gie = 1'b0; irq_req = '1; #2;
    check("R5 masked pend", 32'(pend), 32'd0);
    take = 1'b1; #2;
    check("R5 masked ack", 32'(irq_ack), 32'd0);
    check("R9 masked vec", 32'(vec_addr), 32'h0);
    take = 1'b0;
    settle();
    irq_req = '0; #2;
  endtask

  task automatic t_boot();
    settle();
    gie = 1'b1; nmi_en = 1'b1; irq_req = '1; boot_req = 1'b1; take = 1'b1; #2;
    check("R2 boot pend", 32'(pend), 32'd1);
    check("R2 boot vec", 32'(vec_addr), 32'hFFFE);
    check("R2 boot no ack", 32'(irq_ack), 32'd0);
    take = 1'b0;
    settle();
    boot_req = 1'b0; irq_req = '0; gie = 1'b0; nmi_en = 1'b0; #2;
  endtask

  task automatic t_nmi_edge();
    nmi_en = 1'b1; gie = 1'b1;
    settle();
    nmi_pin = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    check("R7 not yet after 2 edges", 32'(pend), 32'd0);
    @(posedge clk); #2;
    check("R7 pending after 3 edges", 32'(pend), 32'd1);
    check("R3 nmi vec", 32'(vec_addr), 32'hFFFC);
    settle();
    irq_req = '1; #2;
    check("R3 nmi over lines", 32'(vec_addr), 32'hFFFC);
    take = 1'b1; #2;
    check("R6 no ack for nmi", 32'(irq_ack), 32'd0);
    settle();
    take = 1'b0; irq_req = '0; #2;
    check("R8 cleared on accept", 32'(pend), 32'd0);
    repeat (4) settle();
    check("R7 held pin no retrigger", 32'(pend), 32'd0);
    nmi_pin = 1'b0;
    repeat (4) settle();
    gie = 1'b0; nmi_en = 1'b0;
  endtask

  task automatic t_nmi_gated();
    settle();
    nmi_pin = 1'b1;
    settle();
    nmi_pin = 1'b0;
    repeat (4) settle();
    check("R3 disabled nmi hidden", 32'(pend), 32'd0);
    take = 1'b1; #2;
    check("R10 idle take ack", 32'(irq_ack), 32'd0);
    settle();
    take = 1'b0;
    gie = 1'b1; irq_req = 14'h0004; #2;
    check("R3 line wins when nmi disabled", 32'(vec_addr), 32'hFFE4);
    settle();
    gie = 1'b0; irq_req = '0; nmi_en = 1'b1; #2;
    check("R8 latch held while disabled", 32'(pend), 32'd1);
    check("R3 nmi ignores gie", 32'(vec_addr), 32'hFFFC);
    take = 1'b1;
    settle();
    take = 1'b0; #2;
    check("R8 cleared after accept", 32'(pend), 32'd0);
    nmi_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_lines();
    t_priority();
    t_boot();
    t_nmi_edge();
    t_nmi_gated();
    repeat (2) settle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule